// File: doc/BRIEF.md
# Edge-Triggered External Interrupt Bank

This block watches a bank of external interrupt pins, one per line, and turns their transitions into latched interrupt requests. Every pin is first brought into the clock domain through a two-stage synchroniser. A transition is then recognised by comparing the synchronised level with its level one clock earlier. Per-line enable bits choose which transitions count: rising only, falling only, both, or none.

A rising transition is latched in one pending register and a falling transition in another. Software may also raise a rising-side request for any line by writing a one to a trigger register that cannot be read back. Pending bits are cleared by writing ones to them. A per-line mask decides which pending lines drive the per-line request outputs and the combined request output.

Software reaches the registers through a simple single-cycle bus with a write strobe and a read strobe. Read data appears in the cycle after the read strobe and holds its value until the next read. The block has no handshake and no wait states.

Top module: `eirq_bank`

## Requirements
- R1: After reset, every register reads as zero, and `irq_line` and `irq_any` are zero.
- R2: The rising-enable register (offset 0x00), the falling-enable register (0x04) and the mask register (0x80) are read-write; bit n belongs to line n. Read data is registered, valid the cycle after `rd_en`, and holds its value otherwise.
- R3: A line whose rising-enable bit is set latches a low-to-high transition of its pin in the rising-pending register (0x0C) and leaves the falling-pending register (0x10) unchanged.
- R4: A line whose falling-enable bit is set latches a high-to-low transition of its pin in the falling-pending register, and ignores rising transitions unless its rising-enable bit is also set.
- R5: A line with both enable bits set latches both kinds of transition, each in its own pending register.
- R6: A line with neither enable bit set never becomes pending from pin activity.
- R7: Writing a one to a bit of either pending register clears that bit. Writing a zero leaves the bit unchanged.
- R8: Writing a one to bit n of the software-trigger register (0x08) sets bit n of the rising-pending register at that write's clock edge. Reads of 0x08 always return zero.
- R9: If a new event and a clearing write hit the same pending bit in the same cycle, the bit ends up set.
- R10: `irq_line[n]` is high exactly while mask bit n is one and line n is pending in either register. It follows the registers with no added delay.
- R11: `irq_any` is the OR of all `irq_line` bits, delayed by one clock.
- R12: Reads of any offset other than 0x00, 0x04, 0x08, 0x0C, 0x10 and 0x80 return zero.
- R13: A pin change that is present before clock edge k shows in the pending register, and on `irq_line`, after edge k+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_in | input | NLINES | Asynchronous external interrupt pins |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Byte offset of the register |
| wdata | input | NLINES | Write data |
| rdata | output | NLINES | Registered read data |
| irq_line | output | NLINES | Per-line masked interrupt requests |
| irq_any | output | 1 | Registered OR of all per-line requests |

## Verification
The bench targets the set-versus-clear collision. It lines up a clearing write with the exact edge at which a synchronised transition lands, so a design that lets the clear win would lose the event and read back zero. It measures the synchroniser latency to the cycle: one stage too few raises `irq_line` an edge early, and one stage too many raises it an edge late. It also drives pins that have the opposite enable or no enable set, and a design with crossed enable bits would latch those transitions. Finally, it writes zeros to pending registers, reads back the trigger offset, and reads unmapped offsets, and a design that treated the zeros as clears or decoded too few address bits would fail those reads.

// File: rtl/eirq_pkg.sv
package eirq_pkg;
    localparam logic [7:0] OFS_RISE_EN = 8'h00;
    localparam logic [7:0] OFS_FALL_EN = 8'h04;
    localparam logic [7:0] OFS_SW_TRIG = 8'h08;
    localparam logic [7:0] OFS_RISE_PD = 8'h0C;
    localparam logic [7:0] OFS_FALL_PD = 8'h10;
    localparam logic [7:0] OFS_MASK    = 8'h80;
endpackage

// File: rtl/eirq_edge.sv
module eirq_edge #(
    parameter int NLINES = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NLINES-1:0] pins,
    input  logic [NLINES-1:0] rise_en,
    input  logic [NLINES-1:0] fall_en,
    output logic [NLINES-1:0] rise_hit,
    output logic [NLINES-1:0] fall_hit
);
    for (genvar i = 0; i < NLINES; i++) begin : g_line
        logic meta_q, sync_q, last_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                meta_q <= 1'b0;
                sync_q <= 1'b0;
                last_q <= 1'b0;
            end else begin
                meta_q <= pins[i];
                sync_q <= meta_q;
                last_q <= sync_q;
            end
        end

        assign rise_hit[i] = rise_en[i] &  sync_q & ~last_q;
        assign fall_hit[i] = fall_en[i] & ~sync_q &  last_q;
    end
endmodule

// File: rtl/eirq_regs.sv
module eirq_regs
    import eirq_pkg::*;
#(
    parameter int NLINES = 32,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [NLINES-1:0] wdata,
    input  logic [NLINES-1:0] rise_hit,
    input  logic [NLINES-1:0] fall_hit,
    output logic [NLINES-1:0] rise_en,
    output logic [NLINES-1:0] fall_en,
    output logic [NLINES-1:0] rdata,
    output logic [NLINES-1:0] irq_line
);
    localparam logic [ADDR_W-1:0] A_RE = ADDR_W'(OFS_RISE_EN);
    localparam logic [ADDR_W-1:0] A_FE = ADDR_W'(OFS_FALL_EN);
    localparam logic [ADDR_W-1:0] A_SW = ADDR_W'(OFS_SW_TRIG);
    localparam logic [ADDR_W-1:0] A_RP = ADDR_W'(OFS_RISE_PD);
    localparam logic [ADDR_W-1:0] A_FP = ADDR_W'(OFS_FALL_PD);
    localparam logic [ADDR_W-1:0] A_MK = ADDR_W'(OFS_MASK);

    logic [NLINES-1:0] mask_q, rpend_q, fpend_q;
    logic [NLINES-1:0] sw_set, rp_clr, fp_clr, rise_set, rd_mux;

    always_comb begin
        sw_set   = (wr_en && addr == A_SW) ? wdata : '0;
        rp_clr   = (wr_en && addr == A_RP) ? wdata : '0;
        fp_clr   = (wr_en && addr == A_FP) ? wdata : '0;
        rise_set = rise_hit | sw_set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rise_en <= '0;
            fall_en <= '0;
            mask_q  <= '0;
            rpend_q <= '0;
            fpend_q <= '0;
        end else begin
            if (wr_en && addr == A_RE) rise_en <= wdata;
            if (wr_en && addr == A_FE) fall_en <= wdata;
            if (wr_en && addr == A_MK) mask_q  <= wdata;
            rpend_q <= (rpend_q & ~rp_clr) | rise_set;
            fpend_q <= (fpend_q & ~fp_clr) | fall_hit;
        end
    end

    always_comb begin
        unique case (addr)
            A_RE:    rd_mux = rise_en;
            A_FE:    rd_mux = fall_en;
            A_RP:    rd_mux = rpend_q;
            A_FP:    rd_mux = fpend_q;
            A_MK:    rd_mux = mask_q;
            default: rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     rdata <= '0;
        else if (rd_en) rdata <= rd_mux;
    end

    assign irq_line = mask_q & (rpend_q | fpend_q);

    // R9: an event arriving with a clear on the same bit must survive
    a_r9_rise_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (|rise_set) |=> ((rpend_q & $past(rise_set)) == $past(rise_set)));
    a_r9_fall_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (|fall_hit) |=> ((fpend_q & $past(fall_hit)) == $past(fall_hit)));
    // R3: rising-pending bits only appear from an enabled edge or a trigger
    a_r3_rpend_source: assert property (@(posedge clk) disable iff (!rst_n)
        ((rpend_q & ~$past(rpend_q) & ~$past(rise_set)) == '0));
    // R4: falling-pending bits only appear from an enabled falling edge
    a_r4_fpend_source: assert property (@(posedge clk) disable iff (!rst_n)
        ((fpend_q & ~$past(fpend_q) & ~$past(fall_hit)) == '0));
    // R7: a written one clears its bit unless a new event lands
    a_r7_rp_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_RP) |=> ((rpend_q & $past(wdata) & ~$past(rise_set)) == '0));
    // R12: unmapped offsets read zero
    a_r12_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr != A_RE && addr != A_FE && addr != A_RP &&
         addr != A_FP && addr != A_MK) |=> (rdata == '0));
endmodule

// File: rtl/eirq_bank.sv
module eirq_bank #(
    parameter int NLINES = 32,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NLINES-1:0] ext_in,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [NLINES-1:0] wdata,
    output logic [NLINES-1:0] rdata,
    output logic [NLINES-1:0] irq_line,
    output logic              irq_any
);
    logic [NLINES-1:0] rise_en, fall_en, rise_hit, fall_hit;

    eirq_edge #(.NLINES(NLINES)) u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .pins     (ext_in),
        .rise_en  (rise_en),
        .fall_en  (fall_en),
        .rise_hit (rise_hit),
        .fall_hit (fall_hit)
    );

    eirq_regs #(.NLINES(NLINES), .ADDR_W(ADDR_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .rd_en    (rd_en),
        .addr     (addr),
        .wdata    (wdata),
        .rise_hit (rise_hit),
        .fall_hit (fall_hit),
        .rise_en  (rise_en),
        .fall_en  (fall_en),
        .rdata    (rdata),
        .irq_line (irq_line)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) irq_any <= 1'b0;
        else        irq_any <= |irq_line;
    end

    // R11: the combined request trails the per-line requests by one clock
    a_r11_any_follows: assert property (@(posedge clk) disable iff (!rst_n)
        irq_any == $past(|irq_line));
endmodule

// File: tb/tb_eirq_bank.sv
`timescale 1ns/1ps
module tb_eirq_bank;
    localparam int N = 32;
    logic clk = 0, rst_n = 0, wr_en = 0, rd_en = 0;
    logic [7:0] addr = '0;
    logic [N-1:0] ext_in = '0, wdata = '0;
    logic [N-1:0] rdata, irq_line;
    logic irq_any;
    int n_chk = 0, n_bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    eirq_bank dut (.clk(clk), .rst_n(rst_n), .ext_in(ext_in), .wr_en(wr_en),
        .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata),
        .irq_line(irq_line), .irq_any(irq_any));

    // behavioural reference: register values plus a history of sampled pins
    logic [N-1:0] m_re, m_fe, m_mk, m_rp, m_fp, m_rd;
    bit m_any;
    logic [N-1:0] hist[$];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_re = '0; m_fe = '0; m_mk = '0; m_rp = '0; m_fp = '0; m_rd = '0; m_any = 0;
            hist = '{'0, '0, '0};
        end else begin
            logic [N-1:0] up, dn, rdv;
            up = hist[1] & ~hist[2];
            dn = ~hist[1] & hist[2];
            case (addr)
                8'h00: rdv = m_re; 8'h04: rdv = m_fe; 8'h0C: rdv = m_rp;
                8'h10: rdv = m_fp; 8'h80: rdv = m_mk; default: rdv = '0;
            endcase
            if (rd_en) m_rd = rdv;
            m_any = |(m_mk & (m_rp | m_fp));
            begin
                logic [N-1:0] nrp, nfp;
                nrp = m_rp; nfp = m_fp;
                if (wr_en && addr == 8'h0C) nrp = nrp & ~wdata;
                if (wr_en && addr == 8'h10) nfp = nfp & ~wdata;
                nrp = nrp | (up & m_re);
                nfp = nfp | (dn & m_fe);
                if (wr_en && addr == 8'h08) nrp = nrp | wdata;
                m_rp = nrp; m_fp = nfp;
            end
            if (wr_en && addr == 8'h00) m_re = wdata;
            if (wr_en && addr == 8'h04) m_fe = wdata;
            if (wr_en && addr == 8'h80) m_mk = wdata;
            hist.push_front(ext_in);
            void'(hist.pop_back());
        end
    end

    task automatic check(string req, logic [N-1:0] act, logic [N-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R10 lockstep irq_line", irq_line, m_mk & (m_rp | m_fp));
            check("R11 lockstep irq_any", N'(irq_any), N'(m_any));
            check("R2 lockstep rdata", rdata, m_rd);
        end
    end

    task automatic bus_wr(logic [7:0] a, logic [N-1:0] d);
        @(negedge clk); wr_en = 1; addr = a; wdata = d;
        @(negedge clk); wr_en = 0; wdata = '0;
    endtask

    task automatic bus_rd(logic [7:0] a, output logic [N-1:0] d);
        @(negedge clk); rd_en = 1; addr = a;
        @(negedge clk); rd_en = 0; d = rdata;
    endtask

    task automatic idle(int c);
        repeat (c) @(negedge clk);
    endtask

    task automatic finish_up();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        #200000;
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_up();
    end

    initial begin
        logic [N-1:0] v;
        idle(3); rst_n = 1; idle(1);
        // R1: reset state
        bus_rd(8'h00, v); check("R1 rise_en", v, '0);
        bus_rd(8'h04, v); check("R1 fall_en", v, '0);
        bus_rd(8'h0C, v); check("R1 rise_pd", v, '0);
        bus_rd(8'h10, v); check("R1 fall_pd", v, '0);
        bus_rd(8'h80, v); check("R1 mask", v, '0);
        check("R1 outputs", irq_line | N'(irq_any), '0);
        // R2: read-write registers
        bus_wr(8'h00, 32'h5); bus_wr(8'h04, 32'h6); bus_wr(8'h80, 32'hA5A5_0001);
        bus_rd(8'h00, v); check("R2 rise_en", v, 32'h5);
        bus_rd(8'h04, v); check("R2 fall_en", v, 32'h6);
        bus_rd(8'h80, v); check("R2 mask", v, 32'hA5A5_0001);
        bus_wr(8'h80, '1);
        // R13 / R11: latency of line 0
        @(negedge clk); ext_in[0] = 1'b1;
        @(posedge clk); @(posedge clk); @(negedge clk);
        check("R13 not yet after k+1", irq_line, '0);
        @(posedge clk); @(negedge clk);
        check("R13 set after k+2", irq_line, 32'h1);
        check("R11 irq_any still low", N'(irq_any), '0);
        @(posedge clk); @(negedge clk);
        check("R11 irq_any one clock later", N'(irq_any), 32'h1);
        // R3 R4 R5 R6: rising pass on lines 1..3
        ext_in[3:1] = 3'b111; idle(5);
        bus_rd(8'h0C, v); check("R3 R5 R6 rise_pd", v, 32'h5);
        bus_rd(8'h10, v); check("R3 R4 fall_pd unchanged", v, '0);
        ext_in[3:0] = 4'b0000; idle(5);
        bus_rd(8'h10, v); check("R4 R5 R6 fall_pd", v, 32'h6);
        bus_rd(8'h0C, v); check("R4 rise_pd unchanged", v, 32'h5);
        // R7: write-one-to-clear
        bus_wr(8'h0C, '0); bus_rd(8'h0C, v); check("R7 zero write no effect", v, 32'h5);
        bus_wr(8'h0C, 32'h1); bus_rd(8'h0C, v); check("R7 clear one bit", v, 32'h4);
        bus_wr(8'h10, 32'h6); bus_rd(8'h10, v); check("R7 clear fall_pd", v, '0);
        // R10: masking
        bus_wr(8'h80, 32'h1); check("R10 masked line low", irq_line, '0);
        bus_wr(8'h80, 32'h4); check("R10 unmasked line high", irq_line, 32'h4);
        // R8: software trigger
        bus_wr(8'h08, 32'h200); bus_rd(8'h0C, v); check("R8 trigger sets rise_pd", v, 32'h204);
        bus_rd(8'h08, v); check("R8 trigger reads zero", v, '0);
        // R9: set beats clear on the same edge
        bus_wr(8'h0C, '1); idle(2);
        @(negedge clk); ext_in[0] = 1'b1;
        @(posedge clk); @(negedge clk);
        @(posedge clk); @(negedge clk); wr_en = 1; addr = 8'h0C; wdata = 32'h1;
        @(negedge clk); wr_en = 0; wdata = '0;
        bus_rd(8'h0C, v); check("R9 set wins", v, 32'h1);
        // R12: unmapped reads
        bus_rd(8'h14, v); check("R12 offset 14", v, '0);
        bus_rd(8'h40, v); check("R12 offset 40", v, '0);
        bus_rd(8'hFC, v); check("R12 offset FC", v, '0);
        idle(3);
        finish_up();
    end
endmodule